// File: doc/BRIEF.md
# Display Register Write Port over I2C

This block is a write-only I2C target that lets a host microcontroller load a display register file laid out as rows and columns. It oversamples the serial clock and data lines with a fast system clock. Both lines are synchronised and filtered before the block looks for START and STOP conditions and clock edges.

Once the device address matches, the block takes two addressing bytes, a row and then a column. Every following pair of bytes forms one 16-bit word. The first byte of a pair is the high half and the second is the low half. Each completed word comes out as a one-cycle write strobe with its row, column and data, and the column then steps forward by one, so a burst fills neighbouring cells. The register file that takes the strobe sits outside this block. Character cells occupy rows 0 to 14, columns 0 to 29. Row attributes sit in column 30 of those rows. Frame control and PWM registers are in row 15, columns 0 to 8.

Top module: `osd_i2c_regwr`

## Requirements
- R1: The first byte after a START (MSB first) is acknowledged only when it equals 8'hBA. The acknowledge drives SDA low for the whole ninth SCL high phase.
- R2: After any other first byte, the block never drives SDA and produces no write strobe until the next START.
- R3: The second byte selects the row from bits 3:0; bits 7:4 have no effect on the row that is written.
- R4: The third byte selects the column from bits 4:0; bits 7:5 have no effect on the column that is written.
- R5: Every row, column and data byte of an addressed transfer is acknowledged. The data bytes are taken as high/low pairs, and the low byte of each pair produces a strobe whose data is {high, low}.
- R6: Each strobe carries the current column. The column then increases by one, wrapping from 31 to 0, and the row stays the same.
- R7: A STOP that follows an unpaired high byte produces no strobe.
- R8: A repeated START drops any unpaired high byte and returns the block to the device-address phase.
- R9: A pulse on SCL or SDA that is shorter than FILT_LEN system clocks has no effect on the bytes received.
- R10: While reset is asserted, the SDA drive and the write strobe are low.
- R11: The write strobe is high for exactly one system clock per word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | High pulls SDA low (acknowledge) |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_row | output | 4 | Row of the word being written |
| wr_col | output | 5 | Column of the word being written |
| wr_data | output | 16 | Word being written, high byte from the first byte of the pair |

## Verification
The bench targets these failure modes:
- Column wrap from 31 to 0. A design that carried into the row or saturated would write the wrong cell.
- Bursts that end on an unpaired byte, ended by a STOP or by a repeated START. A design that flushed the half word would emit a spurious strobe with stale low data.
- Transfers to a foreign address. A design that did not latch the mismatch would acknowledge later bytes or write data.
- Short glitches on SCL and SDA. An unfiltered design would shift an extra bit or see a false START, and every following word would be corrupted.

// File: rtl/osd_i2c_pkg.sv
package osd_i2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ADDR   = 3'd1,
    ST_ROW    = 3'd2,
    ST_COL    = 3'd3,
    ST_DHI    = 3'd4,
    ST_DLO    = 3'd5,
    ST_IGNORE = 3'd6
  } st_t;

  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int   FILT_LEN = 3,
  parameter logic RST_VAL  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic          s1_q, s2_q;
  logic          out_q, out_n;
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    out_n = out_q;
    cnt_n = cnt_q;
    if (s2_q == out_q) begin
      cnt_n = '0;
    end else if (cnt_q == CW'(FILT_LEN - 1)) begin
      out_n = s2_q;
      cnt_n = '0;
    end else begin
      cnt_n = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= RST_VAL;
      s2_q  <= RST_VAL;
      out_q <= RST_VAL;
      cnt_q <= '0;
    end else begin
      s1_q  <= raw_i;
      s2_q  <= s1_q;
      out_q <= out_n;
      cnt_q <= cnt_n;
    end
  end

  assign filt_o = out_q;
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  assign scl_rise = !scl_p && scl_f;
  assign scl_fall = scl_p && !scl_f;
  assign start_ev = scl_p && scl_f && sda_p && !sda_f;
  assign stop_ev  = scl_p && scl_f && !sda_p && sda_f;
endmodule

// File: rtl/i2c_byte_rx.sv
module i2c_byte_rx #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_f,
  input  logic          restart,
  input  logic          ack_req,
  output logic          byte_done,
  output logic [BW-1:0] byte_q,
  output logic          sda_oe
);
  localparam int CW = $clog2(BW + 1);

  logic [CW-1:0] bit_q, bit_n;
  logic [BW-1:0] sh_q, sh_n;
  logic          ack_q, ack_n;
  logic          oe_q, oe_n;

  assign byte_done = scl_fall && (bit_q == CW'(BW)) && !ack_q;

  always_comb begin
    bit_n = bit_q;
    sh_n  = sh_q;
    ack_n = ack_q;
    oe_n  = oe_q;
    if (restart) begin
      bit_n = '0;
      ack_n = 1'b0;
      oe_n  = 1'b0;
    end else if (byte_done) begin
      ack_n = 1'b1;
      oe_n  = ack_req;
    end else if (scl_fall && ack_q) begin
      ack_n = 1'b0;
      oe_n  = 1'b0;
      bit_n = '0;
    end else if (scl_rise && (bit_q < CW'(BW))) begin
      sh_n  = {sh_q[BW-2:0], sda_f};
      bit_n = bit_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= '0;
      sh_q  <= '0;
      ack_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      bit_q <= bit_n;
      sh_q  <= sh_n;
      ack_q <= ack_n;
      oe_q  <= oe_n;
    end
  end

  assign byte_q = sh_q;
  assign sda_oe = oe_q;
endmodule

// File: rtl/osd_i2c_regwr.sv
module osd_i2c_regwr #(
  parameter int         FILT_LEN = 3,
  parameter logic [7:0] DEV_ADDR = 8'hBA,
  parameter int         ROW_W    = 4,
  parameter int         COL_W    = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       scl_i,
  input  logic                       sda_i,
  output logic                       sda_oe,
  output logic                       wr_stb,
  output logic [ROW_W-1:0]           wr_row,
  output logic [COL_W-1:0]           wr_col,
  output logic [osd_i2c_pkg::WORD_W-1:0] wr_data
);
  import osd_i2c_pkg::*;

  localparam int NLINE = 2;

  logic [NLINE-1:0] raw_lines, filt_lines;
  logic scl_f, sda_f;
  logic scl_rise, scl_fall, start_ev, stop_ev;
  logic byte_done, ack_req;
  logic [BYTE_W-1:0] byte_v;

  assign raw_lines = {scl_i, sda_i};

  for (genvar g = 0; g < NLINE; g++) begin : g_filt
    i2c_line_filter #(.FILT_LEN(FILT_LEN), .RST_VAL(1'b1)) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .raw_i (raw_lines[g]),
      .filt_o(filt_lines[g])
    );
  end

  assign scl_f = filt_lines[1];
  assign sda_f = filt_lines[0];

  i2c_bus_events u_ev (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_f   (scl_f),
    .sda_f   (sda_f),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .start_ev(start_ev),
    .stop_ev (stop_ev)
  );

  i2c_byte_rx #(.BW(BYTE_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .sda_f    (sda_f),
    .restart  (start_ev || stop_ev),
    .ack_req  (ack_req),
    .byte_done(byte_done),
    .byte_q   (byte_v),
    .sda_oe   (sda_oe)
  );

  st_t               state_q, state_n;
  logic [ROW_W-1:0]  row_q, row_n;
  logic [COL_W-1:0]  col_q, col_n;
  logic [BYTE_W-1:0] hi_q, hi_n;
  logic              stb_q, stb_n;
  logic [ROW_W-1:0]  orow_q, orow_n;
  logic [COL_W-1:0]  ocol_q, ocol_n;
  logic [WORD_W-1:0] odat_q, odat_n;

  always_comb begin
    ack_req = 1'b0;
    if (byte_done) begin
      unique case (state_q)
        ST_ADDR:                        ack_req = (byte_v == DEV_ADDR);
        ST_ROW, ST_COL, ST_DHI, ST_DLO: ack_req = 1'b1;
        default:                        ack_req = 1'b0;
      endcase
    end
  end

  always_comb begin
    state_n = state_q;
    row_n   = row_q;
    col_n   = col_q;
    hi_n    = hi_q;
    stb_n   = 1'b0;
    orow_n  = orow_q;
    ocol_n  = ocol_q;
    odat_n  = odat_q;
    if (start_ev) begin
      state_n = ST_ADDR;
    end else if (stop_ev) begin
      state_n = ST_IDLE;
    end else if (byte_done) begin
      unique case (state_q)
        ST_ADDR: state_n = (byte_v == DEV_ADDR) ? ST_ROW : ST_IGNORE;
        ST_ROW: begin
          row_n   = byte_v[ROW_W-1:0];
          state_n = ST_COL;
        end
        ST_COL: begin
          col_n   = byte_v[COL_W-1:0];
          state_n = ST_DHI;
        end
        ST_DHI: begin
          hi_n    = byte_v;
          state_n = ST_DLO;
        end
        ST_DLO: begin
          stb_n   = 1'b1;
          orow_n  = row_q;
          ocol_n  = col_q;
          odat_n  = {hi_q, byte_v};
          col_n   = col_q + COL_W'(1);
          state_n = ST_DHI;
        end
        default: state_n = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
      col_q   <= '0;
      hi_q    <= '0;
      stb_q   <= 1'b0;
      orow_q  <= '0;
      ocol_q  <= '0;
      odat_q  <= '0;
    end else begin
      state_q <= state_n;
      row_q   <= row_n;
      col_q   <= col_n;
      hi_q    <= hi_n;
      stb_q   <= stb_n;
      orow_q  <= orow_n;
      ocol_q  <= ocol_n;
      odat_q  <= odat_n;
    end
  end

  assign wr_stb  = stb_q;
  assign wr_row  = orow_q;
  assign wr_col  = ocol_q;
  assign wr_data = odat_q;
endmodule

// File: rtl/osd_i2c_regwr_chk.sv
module osd_i2c_regwr_chk #(
  parameter int COL_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic              wr_stb,
  input logic [COL_W-1:0]  wr_col,
  input logic [COL_W-1:0]  col_q,
  input osd_i2c_pkg::st_t  state_q
);
  import osd_i2c_pkg::*;

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R10: assert (!sda_oe && !wr_stb)
        else $error("R10: outputs active during reset");
    end
  end

  assert_stb_one_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  assert_stb_after_low_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(state_q) == ST_DLO);

  assert_col_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> col_q == COL_W'(wr_col + COL_W'(1)));

  assert_no_drive_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IGNORE) |-> !sda_oe);

  assert_ack_while_scl_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);
endmodule

bind osd_i2c_regwr osd_i2c_regwr_chk #(.COL_W(COL_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .scl_i  (scl_i),
  .sda_oe (sda_oe),
  .wr_stb (wr_stb),
  .wr_col (wr_col),
  .col_q  (col_q),
  .state_q(state_q)
);

// File: tb/osd_i2c_regwr_test.sv
module osd_i2c_regwr_test;
  localparam int Q = 12;

  logic clk, rst_n, scl_h, sda_h;
  logic sda_oe, wr_stb;
  logic [3:0] wr_row;
  logic [4:0] wr_col;
  logic [15:0] wr_data;
  logic sda_line;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [24:0] got_q[$];
  logic [24:0] exp_q[$];

  assign sda_line = sda_h & ~sda_oe;

  osd_i2c_regwr uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_line),
    .sda_oe(sda_oe), .wr_stb(wr_stb), .wr_row(wr_row), .wr_col(wr_col),
    .wr_data(wr_data)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  always @(negedge clk) if (rst_n && wr_stb) got_q.push_back({wr_row, wr_col, wr_data});

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic i2c_start();
    sda_h = 1; wq(); scl_h = 1; wq(); sda_h = 0; wq(); scl_h = 0; wq();
  endtask

  task automatic i2c_stop();
    sda_h = 0; wq(); scl_h = 1; wq(); sda_h = 1; wq();
  endtask

  // glitch: 0 none, 1 short SCL pulse while low, 2 short SDA low pulse while SCL high
  task automatic i2c_byte(input logic [7:0] b, input int glitch, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_h = b[i]; wq();
      if (glitch == 1 && i == 4) begin
        scl_h = 1; repeat (2) @(negedge clk); scl_h = 0; wq();
      end
      scl_h = 1; wq();
      if (glitch == 2 && i == 3 && b[i]) begin
        sda_h = 0; repeat (2) @(negedge clk); sda_h = 1;
      end
      wq(); scl_h = 0;
    end
    sda_h = 1; wq(); scl_h = 1; wq();
    acked = !sda_line; wq(); scl_h = 0;
  endtask

  function automatic logic [24:0] pack_w(input logic [3:0] r, input logic [4:0] c, input logic [15:0] d);
    return {r, c, d};
  endfunction

  // One transfer; builds expected writes; checks acks
  task automatic xfer(input logic [7:0] addr, input logic [7:0] rb, input logic [7:0] cb,
                      input int nd, input logic [7:0] data[16], input bit rep_start,
                      input int glitch, input string tag);
    bit a;
    bit match = (addr == 8'hBA);
    logic [4:0] c = cb[4:0];
    logic [7:0] hi = 0;
    if (rep_start) begin
      sda_h = 1; wq(); scl_h = 1; wq(); sda_h = 0; wq(); scl_h = 0; wq();
    end else i2c_start();
    i2c_byte(addr, 0, a);
    chk(a == match, match ? "R1 address ack" : "R2 foreign address nack", 32'(a), 32'(match));
    i2c_byte(rb, 0, a);
    chk(a == match, match ? "R3 row ack" : "R2 ignored row", 32'(a), 32'(match));
    i2c_byte(cb, 0, a);
    chk(a == match, match ? "R4 col ack" : "R2 ignored col", 32'(a), 32'(match));
    for (int k = 0; k < nd; k++) begin
      i2c_byte(data[k], (k == 1) ? glitch : 0, a);
      chk(a == match, {"R5 data ack ", tag}, 32'(a), 32'(match));
      if (match) begin
        if (k % 2 == 0) hi = data[k];
        else begin
          exp_q.push_back(pack_w(rb[3:0], c, {hi, data[k]}));
          c = c + 5'd1;
        end
      end
    end
  endtask

  task automatic compare(input string tag);
    repeat (20) @(negedge clk);
    chk(got_q.size() == exp_q.size(), {tag, " write count"}, 32'(got_q.size()), 32'(exp_q.size()));
    for (int k = 0; k < exp_q.size() && k < got_q.size(); k++)
      chk(got_q[k] == exp_q[k], {tag, " write content"}, 32'(got_q[k]), 32'(exp_q[k]));
    got_q.delete();
    exp_q.delete();
  endtask

  initial begin
    logic [7:0] d[16];
    int unused_seed;
    unused_seed = $urandom(32'd1234);
    rst_n = 0; scl_h = 1; sda_h = 1;
    repeat (5) @(negedge clk);
    chk(sda_oe == 0 && wr_stb == 0, "R10 reset state", {30'b0, sda_oe, wr_stb}, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);

    // Directed: upper row/col bits set, two words (R3 R4 R5 R6)
    d[0] = 8'h12; d[1] = 8'h34; d[2] = 8'hAB; d[3] = 8'hCD;
    xfer(8'hBA, 8'hF7, 8'hE3, 4, d, 0, 0, "two words");
    i2c_stop();
    compare("R3 R4 R5 R6 directed");

    // Column wrap 31 -> 0 (R6)
    d[0] = 8'h01; d[1] = 8'h02; d[2] = 8'h03; d[3] = 8'h04;
    xfer(8'hBA, 8'h0F, 8'h1F, 4, d, 0, 0, "wrap");
    i2c_stop();
    compare("R6 column wrap");

    // Odd byte then STOP (R7)
    d[0] = 8'h55; d[1] = 8'h66; d[2] = 8'h77;
    xfer(8'hBA, 8'h03, 8'h05, 3, d, 0, 0, "odd stop");
    i2c_stop();
    compare("R7 odd byte stop");

    // Odd byte then repeated START, new transfer (R8)
    d[0] = 8'h99;
    xfer(8'hBA, 8'h02, 8'h04, 1, d, 0, 0, "odd restart");
    d[0] = 8'hDE; d[1] = 8'hAD;
    xfer(8'hBA, 8'h0E, 8'h1E, 2, d, 1, 0, "after restart");
    i2c_stop();
    compare("R8 repeated start");

    // Foreign address, then repeated START to own address (R2, R8)
    d[0] = 8'h11; d[1] = 8'h22;
    xfer(8'hB8, 8'h01, 8'h01, 2, d, 0, 0, "foreign");
    d[0] = 8'h33; d[1] = 8'h44;
    xfer(8'hBA, 8'h01, 8'h01, 2, d, 1, 0, "own after foreign");
    i2c_stop();
    compare("R2 foreign then own");

    // Glitches (R9)
    d[0] = 8'hA5; d[1] = 8'hFF; d[2] = 8'h3C; d[3] = 8'hC3;
    xfer(8'hBA, 8'h05, 8'h07, 4, d, 0, 1, "scl glitch");
    i2c_stop();
    compare("R9 scl glitch");
    xfer(8'hBA, 8'h06, 8'h08, 4, d, 0, 2, "sda glitch");
    i2c_stop();
    compare("R9 sda glitch");

    // Random transfers
    for (int t = 0; t < 20; t++) begin
      logic [7:0] addr;
      int nd;
      addr = ($urandom_range(0, 4) == 0) ? 8'($urandom()) : 8'hBA;
      nd = $urandom_range(0, 7);
      for (int k = 0; k < 16; k++) d[k] = 8'($urandom());
      xfer(addr, 8'($urandom()), 8'($urandom()), nd, d, 0, 0, "random");
      i2c_stop();
      compare("R5 R6 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule